// File: doc/BRIEF.md
# Parallel Variable-Length Instruction Start Selector

This block sits between an instruction fetch buffer and a bank of parallel decoders. It receives a buffer of 32-bit words that holds instructions of one to five words each, together with a per-word valid mask and the index of the word where the first instruction begins. In a single pass it finds where each of up to `NINST` consecutive instructions begins, so that every decoder can be handed its own instruction in the same cycle. It also reports how many words the valid instructions cover, so the fetch pointer can advance by that amount.

A small length decoder sits on every buffer word. It reads the length that an instruction would have if it began at that word, and from that length it gives the index of the following instruction. The selector does not walk these pointers one after another. It composes them into 2-, 4- and 8-step jump tables and doubles the number of known starts at each stage: start 0 gives start 1, starts 0–1 give starts 2–3, and so on. The depth is therefore logarithmic in the number of instructions.

The input and output are stream interfaces. The input is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. A result that is held with `out_ready` low stays unchanged until it is taken.

Top module: `vls_start_sel`

## Requirements
- R1: When the word at `in_start` holds a legal instruction that lies fully inside the buffer, slot 0 is valid and its start index equals `in_start`.
- R2: The length code of a word is bits [2:0], counted in words. Each valid slot k>0 starts at the start of slot k-1 plus the length code of slot k-1.
- R3: Length codes 0, 6 and 7 are illegal. An instruction whose first word carries one is not valid, and neither is any later slot.
- R4: If any word covered by an instruction has its bit in `in_word_ok` low, that instruction is not valid, and neither is any later slot.
- R5: An instruction that would extend past the last buffer word is not valid. An instruction that ends exactly on the last word is valid, and no slot after it is valid.
- R6: The valid bits in `out_inst_ok` form a contiguous run starting at bit 0. Every slot that is not valid reports start index 0.
- R7: `out_words_used` equals the sum of the length codes of all valid slots.
- R8: At most `NINST` starts are reported. A buffer of sixteen one-word instructions parsed from index 0 gives sixteen valid slots and 16 words used.
- R9: A result appears on the outputs, with `out_valid` high, in the cycle after its input transfer. `in_ready` equals `!out_valid || out_ready`, and `in_ready` is high after reset.
- R10: While `out_valid` is high and `out_ready` is low, the outputs hold their values and any new input is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input buffer is present |
| in_ready | output | 1 | Block can accept the input |
| in_words | input | NWORDS*32 | Word buffer, word i in bits [32i+31:32i] |
| in_word_ok | input | NWORDS | Per-word valid mask |
| in_start | input | clog2(NWORDS) | Index of the first instruction's word |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_start | output | NINST*clog2(NWORDS) | Start index of slot k in bits [4k+3:4k] for the default sizes |
| out_inst_ok | output | NINST | Per-slot valid bit |
| out_words_used | output | clog2(NWORDS+1) | Words covered by the valid slots |

## Verification
On every cycle, the assertions check the stream rules (one-cycle latency, holding while stalled), that the valid bits form a prefix, that invalid slots report index zero, that starts strictly increase, that slot 0 matches the offset, that the word count stays within the buffer, and that every composed jump moves forward or terminates. Only the directed scenarios can show that the start positions and the word count are right. Those scenarios cover illegal length codes, mask holes, instructions that cross the end of the buffer or end exactly on it, non-zero offsets and a completely filled result. The bench compares each of these against its own serial walk of the buffer.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int LEN_W   = 3;
  localparam int MAX_LEN = 5;

  function automatic logic len_legal(input logic [LEN_W-1:0] code);
    return (code >= 3'd1) && (code <= 3'(MAX_LEN));
  endfunction
endpackage

// File: rtl/vls_len_dec.sv
module vls_len_dec
  import vls_pkg::*;
#(
  parameter int NWORDS  = 16,
  parameter int WORD_W  = 32,
  parameter int LEN_LSB = 0,
  parameter int IDX     = 0,
  parameter int PW      = 5
) (
  input  logic [WORD_W-1:0] word,
  input  logic [NWORDS-1:0] mask,
  output logic              inst_ok,
  output logic [LEN_W-1:0]  len,
  output logic [PW-1:0]     succ
);
  // Mask padded with zeros so that spans past the end read as invalid.
  logic [NWORDS+MAX_LEN-1:0] mask_ext;
  logic [LEN_W-1:0]          code;
  logic                      span_ok;

  assign mask_ext = {{MAX_LEN{1'b0}}, mask};
  assign code     = word[LEN_LSB +: LEN_W];
  assign len      = code;

  always_comb begin
    span_ok = 1'b1;
    for (int j = 0; j < MAX_LEN; j++) begin
      if (j < int'(code) && !mask_ext[IDX + j]) span_ok = 1'b0;
    end
  end

  assign inst_ok = len_legal(code) && span_ok;

  always_comb begin
    if (inst_ok && (IDX + int'(code) < NWORDS)) succ = PW'(IDX + int'(code));
    else                                       succ = PW'(NWORDS);
  end
endmodule

// File: rtl/vls_ptr_jump.sv
module vls_ptr_jump #(
  parameter int NWORDS = 16,
  parameter int PW     = 5
) (
  input  logic [(NWORDS+1)*PW-1:0] tbl_in,
  output logic [(NWORDS+1)*PW-1:0] tbl_out
);
  // Composes a k-step pointer table with itself into a 2k-step table.
  always_comb begin
    for (int i = 0; i <= NWORDS; i++) begin
      tbl_out[i*PW +: PW] = tbl_in[int'(tbl_in[i*PW +: PW])*PW +: PW];
    end
  end

  // Every composed jump moves forward or terminates (R2).
  always_comb begin
    for (int i = 0; i < NWORDS; i++) begin
      p_jump_forward_r2: assert (int'(tbl_out[i*PW +: PW]) == NWORDS ||
                                 int'(tbl_out[i*PW +: PW]) > i);
    end
  end
endmodule

// File: rtl/vls_start_sel.sv
module vls_start_sel
  import vls_pkg::*;
#(
  parameter int NWORDS  = 16,
  parameter int NINST   = 16,
  parameter int WORD_W  = 32,
  parameter int LEN_LSB = 0,
  localparam int IW     = $clog2(NWORDS),
  localparam int CW     = $clog2(NWORDS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NWORDS*WORD_W-1:0] in_words,
  input  logic [NWORDS-1:0]      in_word_ok,
  input  logic [IW-1:0]          in_start,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [NINST*IW-1:0]    out_start,
  output logic [NINST-1:0]       out_inst_ok,
  output logic [CW-1:0]          out_words_used
);
  localparam int PW   = IW + 1;
  localparam int NSTG = $clog2(NINST);
  localparam int TBLS = (NSTG > 0) ? NSTG : 1;
  localparam int TW   = (NWORDS + 1) * PW;
  localparam logic [PW-1:0] DEAD = PW'(NWORDS);

  // Per-word length decode.
  logic [NWORDS-1:0]      w_ok;
  logic [LEN_W-1:0]       w_len [NWORDS];
  logic [TBLS-1:0][TW-1:0] jtbl;

  for (genvar i = 0; i < NWORDS; i++) begin : g_dec
    vls_len_dec #(
      .NWORDS(NWORDS), .WORD_W(WORD_W), .LEN_LSB(LEN_LSB), .IDX(i), .PW(PW)
    ) u_dec (
      .word    (in_words[i*WORD_W +: WORD_W]),
      .mask    (in_word_ok),
      .inst_ok (w_ok[i]),
      .len     (w_len[i]),
      .succ    (jtbl[0][i*PW +: PW])
    );
  end
  assign jtbl[0][NWORDS*PW +: PW] = DEAD;

  // 2^s-step tables.
  for (genvar s = 1; s < NSTG; s++) begin : g_jump
    vls_ptr_jump #(.NWORDS(NWORDS), .PW(PW)) u_jump (
      .tbl_in  (jtbl[s-1]),
      .tbl_out (jtbl[s])
    );
  end

  // Start pointers, doubled per stage.
  logic [PW-1:0] ptr [NINST];
  assign ptr[0] = (int'(in_start) < NWORDS) ? PW'(in_start) : DEAD;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    for (genvar j = 0; j < (1 << s); j++) begin : g_slot
      assign ptr[(1 << s) + j] = jtbl[s][int'(ptr[j])*PW +: PW];
    end
  end

  // Slot validity, indices and word count.
  logic [NINST-1:0]    c_ok;
  logic [NINST*IW-1:0] c_start;
  logic [CW-1:0]       c_used;

  always_comb begin
    logic [CW+3:0] acc;
    acc = '0;
    for (int k = 0; k < NINST; k++) begin
      c_ok[k] = (ptr[k] != DEAD) && w_ok[ptr[k][IW-1:0]];
      c_start[k*IW +: IW] = c_ok[k] ? ptr[k][IW-1:0] : '0;
      if (c_ok[k]) acc = acc + (CW+4)'(w_len[ptr[k][IW-1:0]]);
    end
    c_used = acc[CW-1:0];
  end

  // Output register with valid/ready.
  logic load;
  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_start      <= '0;
      out_inst_ok    <= '0;
      out_words_used <= '0;
    end else begin
      if (load) begin
        out_valid      <= 1'b1;
        out_start      <= c_start;
        out_inst_ok    <= c_ok;
        out_words_used <= c_used;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // Assertions.
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_start) &&
    $stable(out_inst_ok) && $stable(out_words_used));

  p_prefix_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_inst_ok + NINST'(1)) & out_inst_ok) == '0);

  p_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) && out_inst_ok[0] |-> out_start[IW-1:0] == $past(in_start));

  p_used_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_words_used) <= NWORDS);

  for (genvar k = 0; k < NINST; k++) begin : g_chk
    p_zero_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_inst_ok[k] |-> out_start[k*IW +: IW] == '0);
    if (k > 0) begin : g_asc
      p_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_inst_ok[k] |-> out_start[k*IW +: IW] > out_start[(k-1)*IW +: IW]);
    end
  end
endmodule

// File: tb/tb_vls_start_sel.sv
module tb_vls_start_sel;
  localparam int NW = 16;
  localparam int NI = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [NW*32-1:0] in_words;
  logic [NW-1:0] m;
  logic [IW-1:0] ofs;
  logic [NI*IW-1:0] out_start;
  logic [NI-1:0] out_inst_ok;
  logic [4:0] out_words_used;
  logic [31:0] w [NW];

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  always_comb for (int i = 0; i < NW; i++) in_words[i*32 +: 32] = w[i];

  vls_start_sel dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_words(in_words), .in_word_ok(m), .in_start(ofs),
    .out_valid(out_valid), .out_ready(out_ready), .out_start(out_start),
    .out_inst_ok(out_inst_ok), .out_words_used(out_words_used)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_len(input int i, input int code);
    w[i] = {29'(32'h0123457 * (i + 3)), 3'(code)};
  endtask

  task automatic fill(input int code);
    for (int i = 0; i < NW; i++) set_len(i, code);
    m = '1;
  endtask

  task automatic apply();
    @(negedge clk);
    in_valid = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Serial walk of the buffer, independent of the parallel design.
  task automatic compare(input string req);
    int pos, used, code;
    bit alive, legal;
    pos = int'(ofs); used = 0; alive = 1;
    chk(out_valid == 1'b1, req, "out_valid", int'(out_valid), 1);
    for (int k = 0; k < NI; k++) begin
      bit eok;
      int est;
      eok = 0; est = 0;
      if (alive) begin
        code = int'(w[pos][2:0]);
        legal = (code >= 1) && (code <= 5) && (pos + code <= NW);
        for (int j = 0; j < code; j++)
          if (pos + j < NW && !m[pos + j]) legal = 0;
        if (legal) begin
          eok = 1; est = pos; used += code; pos += code;
          if (pos >= NW) alive = 0;
        end else alive = 0;
      end
      chk(out_inst_ok[k] == eok, req, $sformatf("ok[%0d]", k),
          int'(out_inst_ok[k]), int'(eok));
      chk(int'(out_start[k*IW +: IW]) == est, req, $sformatf("start[%0d]", k),
          int'(out_start[k*IW +: IW]), est);
    end
    chk(int'(out_words_used) == used, req, "words_used",
        int'(out_words_used), used);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_all_one();
    fill(1); ofs = 0;
    apply();
    compare("R8");
    chk(out_inst_ok == 16'hFFFF, "R8", "all slots", int'(out_inst_ok), 16'hFFFF);
    chk(out_words_used == 5'd16, "R8", "words", int'(out_words_used), 16);
  endtask

  task automatic t_mixed();
    int lens [NW] = '{2, 3, 1, 5, 4, 1, 1, 2, 3, 5, 1, 2, 4, 1, 3, 2};
    for (int i = 0; i < NW; i++) set_len(i, lens[i]);
    m = '1; ofs = 0;
    apply();
    compare("R2");
    chk(int'(out_start[1*IW +: IW]) == 2, "R2", "start[1]",
        int'(out_start[1*IW +: IW]), 2);
    ofs = 5;
    apply();
    compare("R1");
    chk(int'(out_start[IW-1:0]) == 5, "R1", "start[0]", int'(out_start[IW-1:0]), 5);
    compare("R7");
  endtask

  task automatic t_illegal();
    fill(1); set_len(4, 0); ofs = 0;
    apply();
    compare("R3");
    chk(out_inst_ok == 16'h000F, "R3", "code 0 stop", int'(out_inst_ok), 16'h000F);
    chk(int'(out_start[5*IW +: IW]) == 0, "R6", "start[5] zero",
        int'(out_start[5*IW +: IW]), 0);
    fill(1); set_len(2, 6);
    apply();
    chk(out_inst_ok == 16'h0003, "R3", "code 6 stop", int'(out_inst_ok), 16'h0003);
    fill(1); set_len(3, 7); ofs = 3;
    apply();
    chk(out_inst_ok == 16'h0000, "R3", "code 7 first", int'(out_inst_ok), 0);
    chk(out_words_used == 5'd0, "R7", "no words", int'(out_words_used), 0);
  endtask

  task automatic t_mask();
    fill(2); m[5] = 1'b0; ofs = 0;
    apply();
    compare("R4");
    chk(out_inst_ok == 16'h0003, "R4", "mask hole", int'(out_inst_ok), 16'h0003);
  endtask

  task automatic t_edges();
    fill(4); ofs = 2;
    apply();
    compare("R5");
    chk(out_inst_ok == 16'h0007, "R5", "crossing end", int'(out_inst_ok), 16'h0007);
    chk(out_words_used == 5'd12, "R7", "words crossing", int'(out_words_used), 12);
    ofs = 0;
    apply();
    compare("R5");
    chk(out_inst_ok == 16'h000F, "R5", "exact end", int'(out_inst_ok), 16'h000F);
    chk(out_words_used == 5'd16, "R5", "words exact", int'(out_words_used), 16);
  endtask

  task automatic t_stall();
    logic [NI*IW-1:0] s0;
    logic [NI-1:0] k0;
    logic [4:0] u0;
    fill(2); ofs = 1;
    apply();
    s0 = out_start; k0 = out_inst_ok; u0 = out_words_used;
    out_ready = 1'b0;
    fill(3); ofs = 0;
    in_valid = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R10", "in_ready stalled", int'(in_ready), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R10", "valid held", int'(out_valid), 1);
    chk(out_start == s0 && out_inst_ok == k0 && out_words_used == u0, "R10",
        "outputs held", int'(out_words_used), int'(u0));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare("R9");
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    fill(1); ofs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_one();
    t_mixed();
    t_illegal();
    t_mask();
    t_edges();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule